// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block is a state machine that takes a grid-tied power converter from power-on to closed-loop operation. It commands two contactors: the main grid contactor, and the bypass contactor that shorts the series pre-charge resistors. It also releases a controller-enable line. The machine watches a sampled DC-bus voltage word and a strobe that marks each new sample. It runs a fixed sequence:

1. Settle with everything open.
2. Confirm that the bus is discharged.
3. Average a window of sensor samples into per-channel offsets.
4. Close the grid contactor and settle.
5. Wait for the bus to charge to the pre-charge threshold.
6. Close the bypass contactor and settle.
7. Enable control.

If the pre-charge step times out, or the external fault input asserts, both contactors open. The machine then stays latched in a fault state until reset.

Thresholds, the discharge sample count, the settle delay and the pre-charge timeout are run-time inputs. The bus width, sample width, channel count and averaging depth (2^K samples) are parameters.

Top module: `startup_seq`

## Requirements
- R1: An asynchronous active-high `rst` puts the machine in state code 0. In that state `grid_on`, `byp_on`, `ctrl_en` and `fault` are low and every offset is zero. State codes are: 0 init, 1 discharge check, 2 offset capture, 3 grid settle, 4 pre-charge, 5 bypass settle, 6 run, 7 fault.
- R2: In state 0 both contactors are open. The machine stays there for `settle`+1 clock edges, then moves to state 1. Strobes have no effect in state 0.
- R3: State 1 counts consecutive strobed samples with `vbus` strictly below `lo_thr`. A strobed sample at or above `lo_thr` restarts the count, and cycles without a strobe change nothing. The strobe that completes `dis_cnt` good samples moves the machine to state 2; a `dis_cnt` of 0 acts as 1.
- R4: State 2 sums 2^K strobed samples per channel. Each sample is read as a signed two's-complement word, with channel c at bits [c*SW +: SW] of `smp`. The strobe that brings in the last sample writes each channel's floor(sum / 2^K) into the same slice of `offs`, and the machine moves to state 3. The offsets then hold until reset.
- R5: `grid_on` is high in states 3 to 6. State 3 lasts `settle`+1 edges and is followed by state 4.
- R6: In state 4, a strobe with `vbus` at or above `pre_thr` moves the machine to state 5, and `byp_on` rises. A strobe with a lower value does not.
- R7: `byp_on` is high in states 5 and 6. State 5 lasts `settle`+1 edges and is followed by state 6, where `ctrl_en` is high.
- R8: If the threshold has not been seen by the (`pre_tmo`+1)th edge in state 4, that edge moves the machine to state 7.
- R9: `fault_in` high at an edge in any state moves the machine to state 7. In state 7 `fault` is high and `grid_on`, `byp_on` and `ctrl_en` are low.
- R10: State 7 is left only by reset, whatever `vbus`, `smp_stb` and `fault_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| vbus | input | VW | Sampled DC-bus voltage, unsigned |
| smp_stb | input | 1 | Marks a new valid sample on `vbus` and `smp` |
| smp | input | NCH*SW | Sensor samples, signed, channel c at [c*SW +: SW] |
| lo_thr | input | VW | Discharge threshold (bus must be below) |
| pre_thr | input | VW | Pre-charge bypass threshold |
| dis_cnt | input | CW | Consecutive low samples required |
| settle | input | CW | Settle delay in clocks after a contactor command |
| pre_tmo | input | CW | Pre-charge timeout in clocks |
| fault_in | input | 1 | External fault, trips the machine |
| grid_on | output | 1 | Grid contactor close command |
| byp_on | output | 1 | Pre-charge bypass contactor close command |
| ctrl_en | output | 1 | Control loop enable |
| offs | output | NCH*SW | Captured signed offsets per channel |
| state | output | 3 | Current state code |
| fault | output | 1 | Latched fault flag |

## Verification
Two situations are hard to reach from the ports: a discharge run broken just before it completes, and a bus sample exactly at a threshold. Both need a precise strobe pattern. The stimulus table breaks the run with a sample equal to `lo_thr`, inserts unstrobed cycles carrying high values, and presents `pre_thr`-1 and then `pre_thr`. The pre-charge timeout is reached by entering state 4 and withholding strobes for exactly `pre_tmo` edges, then one more. The averaging is checked with a negative channel whose sum is not a multiple of 2^K, which exposes rounding toward zero.

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int VW  = 12,
  parameter int SW  = 12,
  parameter int NCH = 3,
  parameter int K   = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VW-1:0]     vbus,
  input  logic              smp_stb,
  input  logic [NCH*SW-1:0] smp,
  input  logic [VW-1:0]     lo_thr,
  input  logic [VW-1:0]     pre_thr,
  input  logic [CW-1:0]     dis_cnt,
  input  logic [CW-1:0]     settle,
  input  logic [CW-1:0]     pre_tmo,
  input  logic              fault_in,
  output logic              grid_on,
  output logic              byp_on,
  output logic              ctrl_en,
  output logic [NCH*SW-1:0] offs,
  output logic [2:0]        state,
  output logic              fault
);
  localparam int AW = SW + K;
  localparam logic [2:0] S_INIT = 3'd0, S_DISCH = 3'd1, S_OFFS = 3'd2, S_GRID = 3'd3,
                         S_PRECH = 3'd4, S_BYP = 3'd5, S_RUN = 3'd6, S_FAULT = 3'd7;

  logic [2:0]    st;
  logic [CW-1:0] tmr, run;
  logic [K-1:0]  scnt;

  wire          settled = (tmr == settle);
  wire          lo_ok   = vbus < lo_thr;
  wire          hi_ok   = smp_stb && (vbus >= pre_thr);
  wire          last    = &scnt;
  wire [CW:0]   run_nx  = {1'b0, run} + 1'b1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st <= S_INIT; tmr <= '0; run <= '0; scnt <= '0;
    end else if (fault_in && st != S_FAULT) begin
      st <= S_FAULT; tmr <= '0;
    end else begin
      case (st)
        S_INIT:
          if (settled) begin st <= S_DISCH; tmr <= '0; run <= '0; end
          else tmr <= tmr + CW'(1);
        S_DISCH:
          if (smp_stb) begin
            if (!lo_ok) run <= '0;
            else if (run_nx >= {1'b0, dis_cnt}) begin st <= S_OFFS; run <= '0; scnt <= '0; end
            else run <= run_nx[CW-1:0];
          end
        S_OFFS:
          if (smp_stb) begin
            scnt <= scnt + K'(1);
            if (last) begin st <= S_GRID; tmr <= '0; end
          end
        S_GRID:
          if (settled) begin st <= S_PRECH; tmr <= '0; end
          else tmr <= tmr + CW'(1);
        S_PRECH:
          if (hi_ok) begin st <= S_BYP; tmr <= '0; end
          else if (tmr == pre_tmo) st <= S_FAULT;
          else tmr <= tmr + CW'(1);
        S_BYP:
          if (settled) begin st <= S_RUN; tmr <= '0; end
          else tmr <= tmr + CW'(1);
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire signed [SW-1:0] s   = smp[c*SW +: SW];
    logic signed [AW-1:0] acc;
    logic signed [SW-1:0] o;
    wire signed [AW-1:0] sum = acc + AW'(s);
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        acc <= '0; o <= '0;
      end else if (st != S_OFFS || fault_in) begin
        acc <= '0;
      end else if (smp_stb) begin
        acc <= sum;
        if (last) o <= SW'(sum >>> K);
      end
    end
    assign offs[c*SW +: SW] = o;
  end

  assign state   = st;
  assign grid_on = st inside {S_GRID, S_PRECH, S_BYP, S_RUN};
  assign byp_on  = st inside {S_BYP, S_RUN};
  assign ctrl_en = (st == S_RUN);
  assign fault   = (st == S_FAULT);

  a_r9_fault_in_trips: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> (fault && !grid_on && !byp_on && !ctrl_en));
  a_r10_fault_latched: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
  a_r6_bypass_on_threshold: assert property (@(posedge clk) disable iff (rst)
    $rose(byp_on) |-> $past(smp_stb && vbus >= pre_thr));
  a_r5_grid_after_offsets: assert property (@(posedge clk) disable iff (rst)
    $rose(grid_on) |-> $past(st == S_OFFS && smp_stb));
  a_r7_run_after_bypass: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_en) |-> $past(byp_on && grid_on));
  a_r8_timeout_trips: assert property (@(posedge clk) disable iff (rst)
    (st == S_PRECH && tmr == pre_tmo && !hi_ok) |=> fault);
  a_r4_offs_stable: assert property (@(posedge clk) disable iff (rst)
    (st != S_OFFS) |=> $stable(offs));
endmodule

// File: tb/startup_seq_test.sv
module startup_seq_test;
  localparam int VW = 8, SW = 8, NCH = 2, K = 2, CW = 16, NV = 27;

  logic clk = 0, rst = 1, smp_stb = 0, fault_in = 0;
  logic [VW-1:0] vbus = 0, lo_thr = 8'd10, pre_thr = 8'd200;
  logic [NCH*SW-1:0] smp = 0;
  logic [CW-1:0] dis_cnt = 16'd3, settle = 16'd2, pre_tmo = 16'd20;
  logic grid_on, byp_on, ctrl_en, fault;
  logic [NCH*SW-1:0] offs;
  logic [2:0] state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  startup_seq #(.VW(VW), .SW(SW), .NCH(NCH), .K(K), .CW(CW)) uut (
    .clk(clk), .rst(rst), .vbus(vbus), .smp_stb(smp_stb), .smp(smp),
    .lo_thr(lo_thr), .pre_thr(pre_thr), .dis_cnt(dis_cnt), .settle(settle),
    .pre_tmo(pre_tmo), .fault_in(fault_in), .grid_on(grid_on), .byp_on(byp_on),
    .ctrl_en(ctrl_en), .offs(offs), .state(state), .fault(fault));

  // {stb, vbus, s0, s1, expected state after the edge}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd0},
    {1'b1, 8'd5,   8'd0,   8'd0,   3'd0},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd5,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd5,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd50,  8'd0,   8'd0,   3'd1},
    {1'b1, 8'd5,   8'd0,   8'd0,   3'd1},
    {1'b0, 8'd50,  8'd0,   8'd0,   3'd1},
    {1'b1, 8'd9,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd10,  8'd0,   8'd0,   3'd1},
    {1'b1, 8'd0,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd0,   8'd0,   8'd0,   3'd1},
    {1'b1, 8'd0,   8'd0,   8'd0,   3'd2},
    {1'b1, 8'd0,   8'd10,  8'hFD,  3'd2},
    {1'b0, 8'd0,   8'd100, 8'd100, 3'd2},
    {1'b1, 8'd0,   8'd11,  8'hFC,  3'd2},
    {1'b1, 8'd0,   8'd12,  8'hFB,  3'd2},
    {1'b1, 8'd0,   8'hFF,  8'hFA,  3'd3},
    {1'b1, 8'd250, 8'd0,   8'd0,   3'd3},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd3},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd4},
    {1'b1, 8'd199, 8'd0,   8'd0,   3'd4},
    {1'b1, 8'd200, 8'd0,   8'd0,   3'd5},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd5},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd5},
    {1'b0, 8'd0,   8'd0,   8'd0,   3'd6},
    {1'b1, 8'd0,   8'd0,   8'd0,   3'd6}
  };

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [7:0] v, input logic [15:0] d);
    smp_stb = s; vbus = v; smp = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; fault_in = 0; smp_stb = 0;
    @(posedge clk); #1;
    chk("R1 state", state, 0);
    chk("R1 outputs", {grid_on, byp_on, ctrl_en, fault}, 0);
    chk("R1 offsets", offs, 0);
    rst = 0;
  endtask

  task automatic advance_to(input int tgt);
    for (int n = 0; n < 200 && state != tgt; n++)
      step(1'b1, (state == 3'd4) ? 8'd250 : 8'd0, 16'd0);
  endtask

  function automatic string tag(input int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; default: return "R7";
    endcase
  endfunction

  function automatic int outs_for(input int s);
    return {(s >= 3 && s <= 6), (s == 5 || s == 6), (s == 6), (s == 7)};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27], VEC[i][26:19], {VEC[i][10:3], VEC[i][18:11]});
      chk(tag(VEC[i][2:0]), state, VEC[i][2:0]);
      chk({tag(VEC[i][2:0]), " outputs"}, {grid_on, byp_on, ctrl_en, fault}, outs_for(VEC[i][2:0]));
    end
    chk("R4 offset ch0", int'($signed(offs[7:0])), 8);
    chk("R4 offset ch1", int'($signed(offs[15:8])), -5);

    fault_in = 1; step(1'b0, 8'd0, 16'd0); fault_in = 0;
    chk("R9 fault from run", state, 7);
    chk("R9 outputs in fault", {grid_on, byp_on, ctrl_en, fault}, 4'b0001);
    for (int i = 0; i < 10; i++) begin
      fault_in = (i == 3);
      step(1'b1, (i % 2) ? 8'd250 : 8'd0, 16'd0);
    end
    fault_in = 0;
    chk("R10 fault latched", state, 7);

    do_reset();
    advance_to(2);
    chk("R4 reached capture", state, 2);
    fault_in = 1; step(1'b1, 8'd0, 16'd0); fault_in = 0;
    chk("R9 fault from capture", state, 7);

    do_reset();
    advance_to(4);
    chk("R6 reached precharge", state, 4);
    for (int i = 0; i < 20; i++) step(1'b0, 8'd0, 16'd0);
    chk("R8 still precharging", state, 4);
    step(1'b0, 8'd0, 16'd0);
    chk("R8 timeout fault", state, 7);
    chk("R8 contactors open", {grid_on, byp_on}, 0);

    settle = 0; dis_cnt = 1;
    do_reset();
    step(1'b0, 8'd0, 16'd0);
    chk("R2 zero settle", state, 1);
    step(1'b1, 8'd0, 16'd0);
    chk("R3 single sample", state, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule